// File: doc/BRIEF.md
# Shared Interrupt Line Poller

Several external devices pull one active-low interrupt request line, so the line alone does not say which device wants service. This block synchronises the line and, once it sees a request, examines the status bit of one device per clock cycle until it finds a device that is asking for service. It then sends that device a grant pulse one cycle wide. While the line stays asserted after a grant, it polls again, so every requester is served in turn.

The search order is chosen by an input. In fixed-priority mode every search begins at device 0. In rotating mode every search begins at the device after the one served most recently. A search that examines every device and finds none asking for service counts as a spurious request, for example a noise glitch. The search then stops, a saturating counter advances and a sticky flag is raised. After each grant or spurious pass the sequencer waits a short settle interval, so the synchroniser can follow the line before the next decision.

Top module: `irq_poller`

## Requirements
- R1: While rst is high and on the first cycle after it, grant is all zeros, spur_cnt is 0 and spur_flag is 0.
- R2: irq_n passes through two synchronising flops. In fixed mode, with device 0 requesting, the grant to device 0 becomes visible 4 rising edges after irq_n goes low.
- R3: With mode_rr=0, each search begins at device 0 and goes up by index. Whether a device was served before has no effect on the order.
- R4: With mode_rr=1, each search begins at the index after the device served last, wrapping from N_DEV-1 to 0. After reset the last-served index is N_DEV-1.
- R5: If irq_n is still low after a grant and the settle interval, a new search starts, until no device requests service.
- R6: grant is one-hot. bit i means device i. Each grant lasts exactly one cycle.
- R7: A search that examines all N_DEV devices and finds no set bit in dev_status gives no grant. It increments spur_cnt by one, sets spur_flag and returns to idle.
- R8: spur_cnt saturates at 2^CNT_W-1 and stays there while more spurious passes occur.
- R9: spur_flag stays set until reset, also across later successful grants.
- R10: A grant goes only to a device whose dev_status bit was set in the cycle before the grant appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_n | input | 1 | Shared active-low request line, asynchronous |
| mode_rr | input | 1 | 0 = fixed priority from device 0, 1 = rotating start |
| dev_status | input | N_DEV | Per-device "I raised the request" status bits |
| grant | output | N_DEV | One-hot service grant, one cycle wide |
| spur_cnt | output | CNT_W | Saturating count of unclaimed search passes |
| spur_flag | output | 1 | Sticky spurious-request indicator |

## Verification
Some properties hold on every cycle, and the assertions check these: grant is one-hot and lasts one cycle, every grant matches a status bit that was set, the flag is sticky, the counter only ever moves up by one, and it holds at saturation. Other behaviour can only be shown by the bench scenarios. These cover the search order in each mode, including the rotating wrap and proof that fixed mode ignores history. They also cover the exact synchroniser latency, repeated service while the line stays low, a one-cycle glitch giving exactly one spurious count, and a line stuck low driving the counter to saturation.

// File: rtl/irq_poll_pkg.sv
package irq_poll_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_POLL = 2'd1,
    ST_COOL = 2'd2
  } poll_state_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_n,
  output logic req
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= ~line_n;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], ~line_n};
      end
    end
  endgenerate

  assign req = sh[STAGES-1];
endmodule

// File: rtl/poll_seq.sv
module poll_seq
  import irq_poll_pkg::*;
#(
  parameter int N_DEV  = 4,
  parameter int SETTLE = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             mode_rr,
  input  logic [N_DEV-1:0] dev_status,
  output logic [N_DEV-1:0] grant,
  output logic             spur_pulse
);
  localparam int IDX_W = (N_DEV > 1) ? $clog2(N_DEV) : 1;
  localparam int CL_W  = $clog2(SETTLE + 1);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(N_DEV - 1);

  poll_state_t      state;
  logic [IDX_W-1:0] ptr;
  logic [IDX_W-1:0] last;
  logic [IDX_W-1:0] steps;
  logic [CL_W-1:0]  cool;

  function automatic logic [IDX_W-1:0] step_idx(input logic [IDX_W-1:0] i);
    return (i == TOP_IDX) ? '0 : i + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      ptr        <= '0;
      last       <= TOP_IDX;
      steps      <= '0;
      cool       <= '0;
      grant      <= '0;
      spur_pulse <= 1'b0;
    end else begin
      grant      <= '0;
      spur_pulse <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req) begin
            state <= ST_POLL;
            ptr   <= mode_rr ? step_idx(last) : '0;
            steps <= '0;
          end
        end
        ST_POLL: begin
          if (dev_status[ptr]) begin
            grant <= N_DEV'(1) << ptr;
            last  <= ptr;
            state <= ST_COOL;
            cool  <= '0;
          end else if (steps == TOP_IDX) begin
            spur_pulse <= 1'b1;
            state      <= ST_COOL;
            cool       <= '0;
          end else begin
            ptr   <= step_idx(ptr);
            steps <= steps + 1'b1;
          end
        end
        ST_COOL: begin
          if (cool == CL_W'(SETTLE - 1)) state <= ST_IDLE;
          else                           cool  <= cool + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spur_counter.sv
module spur_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  output logic [CNT_W-1:0] count,
  output logic             flag
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      flag  <= 1'b0;
    end else if (hit) begin
      flag <= 1'b1;
      if (count != CMAX) count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/irq_poller.sv
module irq_poller #(
  parameter int N_DEV       = 4,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             irq_n,
  input  logic             mode_rr,
  input  logic [N_DEV-1:0] dev_status,
  output logic [N_DEV-1:0] grant,
  output logic [CNT_W-1:0] spur_cnt,
  output logic             spur_flag
);
  localparam int SETTLE = SYNC_STAGES;

  logic req_s;
  logic spur_hit;

  irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .line_n(irq_n), .req(req_s)
  );

  poll_seq #(.N_DEV(N_DEV), .SETTLE(SETTLE)) u_seq (
    .clk(clk), .rst(rst), .req(req_s), .mode_rr(mode_rr),
    .dev_status(dev_status), .grant(grant), .spur_pulse(spur_hit)
  );

  spur_counter #(.CNT_W(CNT_W)) u_spur (
    .clk(clk), .rst(rst), .hit(spur_hit), .count(spur_cnt), .flag(spur_flag)
  );
endmodule

// File: rtl/irq_poller_chk.sv
module irq_poller_chk #(
  parameter int N_DEV = 4,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [N_DEV-1:0] grant,
  input logic [N_DEV-1:0] dev_status,
  input logic [CNT_W-1:0] spur_cnt,
  input logic             spur_flag
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  a_r6_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  a_r6_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (grant != '0) |=> (grant == '0));

  a_r10_claimed: assert property (@(posedge clk) disable iff (rst)
    (grant != '0) |-> (($past(dev_status) & grant) != '0));

  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    spur_flag |=> spur_flag);

  a_r8_hold_max: assert property (@(posedge clk) disable iff (rst)
    (spur_cnt == CMAX) |=> (spur_cnt == CMAX));

  a_r7_step_one: assert property (@(posedge clk) disable iff (rst)
    (spur_cnt != $past(spur_cnt)) |-> (spur_cnt == CNT_W'($past(spur_cnt) + 1'b1)));

  a_r7_flag_with_count: assert property (@(posedge clk) disable iff (rst)
    (spur_cnt != '0) |-> spur_flag);
endmodule

bind irq_poller irq_poller_chk #(.N_DEV(N_DEV), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .grant(grant), .dev_status(dev_status),
  .spur_cnt(spur_cnt), .spur_flag(spur_flag)
);

// File: tb/irq_poller_tb.sv
`timescale 1ns/1ps
module irq_poller_tb;
  localparam int N_DEV = 4;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             irq_n = 1'b1;
  logic             mode_rr = 1'b0;
  logic [N_DEV-1:0] dev_stat = '0;
  logic [N_DEV-1:0] grant;
  logic [CNT_W-1:0] spur_cnt;
  logic             spur_flag;

  int errors = 0;
  int checks = 0;
  int exp_q[$];
  string tag_q[$];
  logic [N_DEV-1:0] prev_grant = '0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_poller #(.N_DEV(N_DEV), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .irq_n(irq_n), .mode_rr(mode_rr),
    .dev_status(dev_stat), .grant(grant), .spur_cnt(spur_cnt), .spur_flag(spur_flag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_grant(input int idx, input string req);
    exp_q.push_back(idx);
    tag_q.push_back(req);
  endtask

  // monitor: R6 one-hot and pulse width, scoreboard of grant order
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (grant != '0) begin
        int idx;
        string t;
        idx = -1;
        for (int i = 0; i < N_DEV; i++) if (grant[i]) idx = i;
        check($countones(grant) == 1, "R6 onehot", $countones(grant), 1);
        check(prev_grant == '0, "R6 one-cycle", prev_grant, 0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected grant", idx, -1);
        end else begin
          int e;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(idx == e, t, idx, e);
        end
      end
      prev_grant = grant;
    end
  end

  task automatic run_burst(input logic rr, input logic [N_DEV-1:0] mask,
                           input int lat, input string req);
    int n;
    bit first;
    @(negedge clk);
    mode_rr  = rr;
    dev_stat = mask;
    irq_n    = 1'b0;
    n = 0;
    first = 1'b1;
    while (dev_stat != '0 && n < 300) begin
      @(negedge clk);
      n++;
      if (grant != '0) begin
        if (first && lat > 0) check(n == lat, req, n, lat);
        first = 1'b0;
        dev_stat = dev_stat & ~grant;
        if (dev_stat == '0) irq_n = 1'b1;
      end
    end
    irq_n = 1'b1;
    check(dev_stat == '0, {req, " all served"}, dev_stat, 0);
    dev_stat = '0;
    repeat (8) @(negedge clk);
    check(exp_q.size() == 0, {req, " queue drained"}, exp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(grant == '0, "R1 grant", grant, 0);
    check(spur_cnt == 0, "R1 count", spur_cnt, 0);
    check(spur_flag == 1'b0, "R1 flag", spur_flag, 0);
    rst = 1'b0;
    @(negedge clk);
    check(grant == '0 && spur_cnt == 0 && !spur_flag, "R1 after release", spur_cnt, 0);

    // R2 latency, fixed mode device 0
    expect_grant(0, "R2 first grant");
    run_burst(1'b0, 4'b0001, 4, "R2 latency");

    // R3 fixed order, R5 repeat while line stays low
    expect_grant(1, "R3 fixed first");
    expect_grant(3, "R5 repeat second");
    run_burst(1'b0, 4'b1010, 0, "R3 burst");
    expect_grant(2, "R3 single");
    run_burst(1'b0, 4'b0100, 0, "R3 single burst");

    // R4 rotating: last=2 -> start 3, then 0, then 1
    expect_grant(3, "R4 start after last");
    expect_grant(0, "R4 wrap");
    expect_grant(1, "R4 third");
    run_burst(1'b1, 4'b1011, 0, "R4 burst");
    // last=1 -> 2, then search from 3 wraps to 1
    expect_grant(2, "R4 next");
    expect_grant(1, "R4 wrap search");
    run_burst(1'b1, 4'b0110, 0, "R4 burst2");

    // R3 fixed ignores history: last=1, still 0 before 3
    expect_grant(0, "R3 ignores last");
    expect_grant(3, "R3 then 3");
    run_burst(1'b0, 4'b1001, 0, "R3 burst2");

    // R7 glitch, no claimant
    check(spur_flag == 1'b0 && spur_cnt == 0, "R7 before glitch", spur_cnt, 0);
    @(negedge clk);
    irq_n = 1'b0;
    @(negedge clk);
    irq_n = 1'b1;
    repeat (30) @(negedge clk);
    check(spur_cnt == 1, "R7 count", spur_cnt, 1);
    check(spur_flag == 1'b1, "R7 flag", spur_flag, 1);

    // R9 sticky across a good grant
    expect_grant(2, "R9 grant");
    run_burst(1'b0, 4'b0100, 0, "R9 burst");
    check(spur_flag == 1'b1, "R9 sticky", spur_flag, 1);
    check(spur_cnt == 1, "R9 count unchanged", spur_cnt, 1);

    // R8 stuck line saturates counter
    @(negedge clk);
    irq_n = 1'b0;
    repeat (3000) @(negedge clk);
    check(spur_cnt == 8'hFF, "R8 saturated", spur_cnt, 255);
    irq_n = 1'b1;
    repeat (20) @(negedge clk);
    check(spur_cnt == 8'hFF, "R8 held", spur_cnt, 255);
    check(spur_flag == 1'b1, "R9 still set", spur_flag, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule